// File: doc/BRIEF.md
# Separate-Port SRAM Access Front End

This block is the synchronous command and data front end of an SRAM that has an independent read port and an independent write port. It also contains the storage array, which is built from ordinary flip-flop or inferred memory. All control inputs are sampled only on the rising edge of `clk`. Each select is active-low. A write select that is low starts a write. The write can be limited to chosen byte lanes through an active-low per-lane mask. A read select that is low starts a read. The word that was read appears after a fixed number of edges, and `rd_valid` marks it.

Both ports can be used on the same edge. If they use the same address, the read returns the word that was stored before that edge's write (read-before-write).

The read return is a valid-only stream with no back-pressure. The consumer must take every word in the cycle in which `rd_valid` is high. No ready input exists, because an SRAM read cannot be stalled once it has started.

Between returns, `rd_data` keeps the last word that was returned. Reset clears only the read pipeline's valid state and leaves the stored contents untouched.

Top module: `sfe_top`

## Requirements
- R1: While reset is asserted, and in every cycle after reset until a read sampled after reset completes, `rd_valid` is 0. A read that was in flight when reset arrived never shows up as valid.
- R2: A read sampled at rising edge t (`rd_sel_n` = 0) drives the stored word of `rd_addr` onto `rd_data`, with `rd_valid` = 1, after rising edge t+LAT-1. With the default LAT = 2 this is the edge after the sampling edge. `rd_valid` is high for exactly one cycle per read.
- R3: A write sampled with `wr_sel_n` = 0 and all mask bits 0 stores the whole `wr_data` word at `wr_addr`.
- R4: Mask bit i guards byte lane i, which is bits [8i+7:8i] of the word. A 0 in bit i lets that lane be written. A 1 leaves that lane of the stored word unchanged, and this includes the case where every bit is 1.
- R5: When `wr_sel_n` = 1, the array is not changed, whatever the values of `wr_addr`, `wr_data` and the mask.
- R6: If a read and a write hit the same address on the same edge, the read returns the word held before that write. The write still takes effect for later reads.
- R7: Reads sampled on consecutive edges return on consecutive cycles, in issue order, and `rd_valid` stays high throughout.
- R8: In a cycle with `rd_valid` = 0, `rd_data` equals its value in the previous cycle.
- R9: Reset does not alter array contents. A word written before reset reads back unchanged after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all accesses start on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read-return pipeline |
| rd_sel_n | input | 1 | Active-low read select |
| rd_addr | input | ADDR_W | Read address |
| wr_sel_n | input | 1 | Active-low write select |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8*NBYTES | Write data word |
| wr_mask_n | input | NBYTES | Active-low per-lane write mask, bit i guards byte i |
| rd_data | output | 8*NBYTES | Returned read word, held between returns |
| rd_valid | output | 1 | High for one cycle for each returned word |

## Verification
The bench targets the following cases:

- A read and a write to the same address on the same edge. A design that forwards the write data would return the new word instead of the old one.
- Masks that enable only some lanes, and a mask with every lane disabled. A design with an inverted or shifted mask would corrupt untouched lanes or drop the lanes that should be written.
- A write whose select is inactive but whose data and mask are live. This must change nothing.
- Reset that arrives while a read is in flight. A pipeline that does not clear its valid state would emit a stray valid, and a reset that wipes the array would lose a stored word.
- Idle cycles between returns. An output register that reloads on every edge would let `rd_data` drift.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  // Width of one byte lane of the stored word.
  localparam int unsigned LANE_W = 8;

  // A lane is written only when the write select and that lane's mask are both low.
  function automatic logic lane_write(input logic sel_n, input logic mask_n);
    return (!sel_n) && (!mask_n);
  endfunction

endpackage

// File: rtl/sfe_req_decode.sv
module sfe_req_decode #(
  parameter int unsigned NBYTES = 4
) (
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [NBYTES-1:0] wr_mask_n,
  output logic              rd_go,
  output logic [NBYTES-1:0] lane_we
);
  import sfe_pkg::*;

  assign rd_go = !rd_sel_n;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_we[b] = lane_write(wr_sel_n, wr_mask_n[b]);
  end

endmodule

// File: rtl/sfe_byte_array.sv
module sfe_byte_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NBYTES = 4,
  localparam int unsigned DATA_W = sfe_pkg::LANE_W * NBYTES,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [NBYTES-1:0] lane_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  import sfe_pkg::*;

  // One independent storage column per byte lane. A lane's read register
  // samples the old contents, because the write updates at the same edge
  // through a nonblocking assignment (read-before-write).
  for (genvar b = 0; b < NBYTES; b++) begin : g_col
    logic [LANE_W-1:0] col_mem [DEPTH];
    logic [LANE_W-1:0] col_rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[b]) begin
        col_mem[wr_addr] <= wr_data[b*LANE_W +: LANE_W];
      end
      if (rd_go) begin
        col_rd_q <= col_mem[rd_addr];
      end
    end

    assign rd_word[b*LANE_W +: LANE_W] = col_rd_q;
  end

endmodule

// File: rtl/sfe_rd_pipe.sv
module sfe_rd_pipe #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  if (LAT <= 1) begin : g_direct
    // The array read register is the only stage.
    logic vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= rd_go;
    end
    assign out_data  = arr_word;
    assign out_valid = vld_q;
  end else begin : g_chain
    // vld_q[0] tracks the array read register. Stages 1..LAT-1 move data
    // forward only when the stage behind them holds a valid word, so each
    // stage keeps its value between reads.
    logic [LAT-1:0]    vld_q;
    logic [DATA_W-1:0] dat_q [1:LAT-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= {vld_q[LAT-2:0], rd_go};
    end

    always_ff @(posedge clk) begin
      if (vld_q[0]) dat_q[1] <= arr_word;
      for (int k = 2; k < LAT; k++) begin
        if (vld_q[k-1]) dat_q[k] <= dat_q[k-1];
      end
    end

    assign out_data  = dat_q[LAT-1];
    assign out_valid = vld_q[LAT-1];
  end

endmodule

// File: rtl/sfe_top.sv
module sfe_top #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NBYTES = 4,
  parameter int unsigned LAT    = 2,
  localparam int unsigned DATA_W = sfe_pkg::LANE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NBYTES-1:0] wr_mask_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic              rd_go;
  logic [NBYTES-1:0] lane_we;
  logic [DATA_W-1:0] arr_word;

  sfe_req_decode #(.NBYTES(NBYTES)) u_dec (
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .wr_mask_n(wr_mask_n),
    .rd_go    (rd_go),
    .lane_we  (lane_we)
  );

  sfe_byte_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_arr (
    .clk    (clk),
    .lane_we(lane_we),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_go  (rd_go),
    .rd_addr(rd_addr),
    .rd_word(arr_word)
  );

  sfe_rd_pipe #(.DATA_W(DATA_W), .LAT(LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_go    (rd_go),
    .arr_word (arr_word),
    .out_data (rd_data),
    .out_valid(rd_valid)
  );

endmodule

// File: rtl/sfe_top_chk.sv
module sfe_top_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT    = 2,
  localparam int unsigned CNT_W = $clog2(LAT + 2) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_sel_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);

  // Independent record of the read selects seen at the port.
  logic [LAT-1:0] req_sr;
  logic [CNT_W-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sr    <= '0;
      since_rst <= '0;
    end else begin
      req_sr <= (LAT > 1) ? {req_sr, !rd_sel_n} : LAT'(!rd_sel_n);
      if (since_rst != {CNT_W{1'b1}}) since_rst <= since_rst + 1'b1;
    end
  end

  AST_RETURN_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == req_sr[LAT-1]); // R2

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (since_rst >= CNT_W'(LAT))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= CNT_W'(1)) && !rd_valid) |-> $stable(rd_data)); // R8

  AST_STREAM_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sr[LAT-1] && (since_rst >= CNT_W'(LAT))) |-> rd_valid); // R7

endmodule

bind sfe_top sfe_top_chk #(.DATA_W(DATA_W), .LAT(LAT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_sel_n(rd_sel_n),
  .rd_data (rd_data),
  .rd_valid(rd_valid)
);

// File: tb/tb_sfe_top.sv
module tb_sfe_top;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int LT = 2;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_sel_n;
  logic [AW-1:0] rd_addr;
  logic        wr_sel_n;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [NB-1:0] wr_mask_n;
  logic [31:0] rd_data;
  logic        rd_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sfe_top #(.ADDR_W(AW), .NBYTES(NB), .LAT(LT)) dut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask_n(wr_mask_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  wa;
    logic [31:0] wd;
    logic [3:0]  bm;
    logic        re;
    logic [5:0]  ra;
    logic [31:0] ex;
  } vec_t;

  // The expected value is the word the row's read must return.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'd3, 32'h11223344, 4'b0000, 1'b0, 6'd0, 32'h0},
    '{1'b1, 6'd5, 32'hA5A5A5A5, 4'b0000, 1'b1, 6'd3, 32'h11223344},
    '{1'b1, 6'd3, 32'hFFEEDDCC, 4'b1010, 1'b1, 6'd5, 32'hA5A5A5A5},
    '{1'b0, 6'd5, 32'h00000000, 4'b0000, 1'b1, 6'd3, 32'h11EE33CC},
    '{1'b1, 6'd5, 32'h12345678, 4'b0000, 1'b1, 6'd5, 32'hA5A5A5A5},
    '{1'b1, 6'd5, 32'hDEADBEEF, 4'b1111, 1'b1, 6'd5, 32'h12345678},
    '{1'b0, 6'd0, 32'h0,        4'b1111, 1'b1, 6'd5, 32'h12345678},
    '{1'b1, 6'd3, 32'h77000000, 4'b0111, 1'b1, 6'd3, 32'h11EE33CC},
    '{1'b0, 6'd0, 32'h0,        4'b1111, 1'b1, 6'd3, 32'h77EE33CC},
    '{1'b0, 6'd0, 32'h0,        4'b1111, 1'b0, 6'd0, 32'h0}
  };

  function automatic string row_tag(input int j);
    case (j)
      1: return "R3";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R3";
      6: return "R4";
      7: return "R6";
      8: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_idle();
    rd_sel_n = 1'b1; rd_addr = '0; wr_sel_n = 1'b1;
    wr_addr = '0; wr_data = '0; wr_mask_n = '1;
  endtask

  task automatic drive_vec(input vec_t v);
    wr_sel_n = !v.we; wr_addr = v.wa; wr_data = v.wd; wr_mask_n = v.bm;
    rd_sel_n = !v.re; rd_addr = v.ra;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    bit have_last;
    have_last = 0;
    last = '0;
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'b0, rd_valid}, 32'd0);

    // Table walk: at iteration i the outputs reflect row i-LT.
    for (int i = 0; i < NV + LT; i++) begin
      if (i >= LT) begin
        int j;
        j = i - LT;
        if (VEC[j].re) begin
          chk((j > 0 && VEC[j-1].re) ? "R7" : "R2", {31'b0, rd_valid}, 32'd1);
          chk(row_tag(j), rd_data, VEC[j].ex);
          last = VEC[j].ex;
          have_last = 1;
        end else begin
          chk("R2", {31'b0, rd_valid}, 32'd0);
          if (have_last) chk("R8", rd_data, last);
        end
      end
      if (i < NV) drive_vec(VEC[i]);
      else        drive_idle();
      @(negedge clk);
    end

    // Idle hold: the output must not drift.
    for (int k = 0; k < 3; k++) begin
      chk("R8", {31'b0, rd_valid}, 32'd0);
      chk("R8", rd_data, 32'h77EE33CC);
      @(negedge clk);
    end

    // Reset arriving with a read in flight.
    rd_sel_n = 1'b0; rd_addr = 6'd5;
    @(negedge clk);
    drive_idle();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {31'b0, rd_valid}, 32'd0);
    @(negedge clk);
    chk("R1", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'b0, rd_valid}, 32'd0);
    @(negedge clk);
    chk("R1", {31'b0, rd_valid}, 32'd0);

    // Contents survive reset.
    rd_sel_n = 1'b0; rd_addr = 6'd3;
    @(negedge clk);
    rd_sel_n = 1'b0; rd_addr = 6'd5;
    @(negedge clk);
    drive_idle();
    chk("R9", {31'b0, rd_valid}, 32'd1);
    chk("R9", rd_data, 32'h77EE33CC);
    @(negedge clk);
    chk("R7", {31'b0, rd_valid}, 32'd1);
    chk("R9", rd_data, 32'h12345678);
    @(negedge clk);
    chk("R2", {31'b0, rd_valid}, 32'd0);
    chk("R8", rd_data, 32'h12345678);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule